// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block moves one of five on-chip PLLs to a new integer-mode divider setting without ever routing a transient clock to its consumers. A request carries a PLL index and the reference, feedback and two post divider values. The sequencer first judges whether the request is legal: the VCO and output frequencies it implies must fall in range, and the feedback divider must fall in range. Only then does it touch any register.

A legal request runs a fixed sequence. The selected PLL's output is switched to the slow reference, integer mode is forced, and the divider fields are written. The sequencer then polls the PLL's lock flag. Once lock is seen, it switches the output back to normal mode. Each register update is a read-modify-write through a combinational read port and a single-cycle write port, so unrelated bits survive. If lock does not arrive within a configurable number of cycles, the sequence aborts with the PLL left on the slow clock.

Top module: `pll_reprog_seq`

## Requirements
- R1: With VCO = 24 MHz × fbdiv / refdiv, a request is accepted only if 800 ≤ VCO ≤ 3200 MHz and 16 ≤ fbdiv ≤ 3200, both inclusive.
- R2: The output frequency VCO / (postdiv1 × postdiv2) must lie in 16..3200 MHz inclusive. A zero refdiv, a zero postdiv1, a zero postdiv2 or a PLL index above 4 makes the request illegal.
- R3: An illegal request produces a one-cycle err_illegal_o pulse in the cycle after it is sampled. It issues no write, and busy_o stays low.
- R4: The first write comes in the cycle after acceptance. It goes to address 0, the mode register, and clears only the selected PLL's mode bit. That bit is at position 0, 1, 4, 8 or 12 for PLL 0 to 4.
- R5: The second write, in the next cycle, goes to control word 1 at address 2+2·idx and sets bit 12 (integer mode).
- R6: The third write goes to control word 0 at address 1+2·idx, with fbdiv in bits 11:0 and postdiv1 in bits 14:12. The fourth write goes to control word 1, with refdiv in bits 5:0 and postdiv2 in bits 8:6. These writes come in consecutive cycles.
- R7: Every write carries the value read from rd_data_i at the same address in the same cycle. Only the fields named in R4 to R6 and R8 are changed in that value.
- R8: After the fourth write, the sequencer reads word 1 every cycle and tests bit 10 (lock). In the cycle after it first sees a 1, it writes the mode bit back to 1. done_o pulses in the cycle after that write.
- R9: If LOCK_TIMEOUT consecutive poll cycles see no lock, err_timeout_o pulses and no mode write follows, so the PLL stays in slow mode.
- R10: busy_o is high from the cycle after acceptance through the final write or the last poll cycle. A request that arrives while busy_o is high is ignored.
- R11: After reset, busy_o, wr_en_o, done_o, err_illegal_o and err_timeout_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, sampled when idle |
| req_pll_i | input | 3 | PLL index 0..4 |
| req_refdiv_i | input | 6 | Reference divider |
| req_fbdiv_i | input | 12 | Feedback divider |
| req_pd1_i | input | 3 | First post divider |
| req_pd2_i | input | 3 | Second post divider |
| rd_addr_o | output | 4 | Register read address |
| rd_data_i | input | 16 | Combinational read data |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 4 | Register write address |
| wr_data_o | output | 16 | Register write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Pulse: PLL restored to normal mode |
| err_illegal_o | output | 1 | Pulse: request rejected |
| err_timeout_o | output | 1 | Pulse: lock wait aborted |

## Verification
A sequencer stuck in the wrong state shows at the ports within one cycle. A write appears out of order, at the wrong address, or not at all, and the write order is checked event by event against an independent model. A fault in the field merge or the bit positions corrupts wr_data_o on the very write it affects. A fault in the lock poll or the timeout counter shifts the mode restore write, or the error pulse, by a number of cycles that the bench's lock model makes predictable.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int unsigned NUM_PLL  = 5;
  localparam int unsigned IDX_W    = 3;
  localparam int unsigned REFDIV_W = 6;
  localparam int unsigned FBDIV_W  = 12;
  localparam int unsigned PDIV_W   = 3;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned INT_BIT  = 12;
  localparam int unsigned LOCK_BIT = 10;
  localparam int unsigned FB_LSB   = 0;
  localparam int unsigned PD1_LSB  = 12;
  localparam int unsigned REF_LSB  = 0;
  localparam int unsigned PD2_LSB  = 6;
  localparam logic [ADDR_W-1:0] MODE_ADDR = '0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SLOW, ST_INT, ST_DIV0, ST_DIV1, ST_POLL, ST_NORM
  } seq_state_e;

  typedef struct packed {
    logic [IDX_W-1:0]    pll;
    logic [REFDIV_W-1:0] refdiv;
    logic [FBDIV_W-1:0]  fbdiv;
    logic [PDIV_W-1:0]   pd1;
    logic [PDIV_W-1:0]   pd2;
  } pll_req_t;

  function automatic logic [3:0] mode_pos(logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    return 4'd0;
      3'd1:    return 4'd1;
      3'd2:    return 4'd4;
      3'd3:    return 4'd8;
      default: return 4'd12;
    endcase
  endfunction

  // word 0 at 1+2*idx, word 1 at 2+2*idx
  function automatic logic [ADDR_W-1:0] ctl_addr(logic [IDX_W-1:0] idx, logic word);
    return ADDR_W'({idx, word}) + ADDR_W'(1);
  endfunction
endpackage

// File: rtl/pll_req_check.sv
module pll_req_check
  import pll_seq_pkg::*;
#(
  parameter int unsigned REF_MHZ     = 24,
  parameter int unsigned VCO_MIN_MHZ = 800,
  parameter int unsigned VCO_MAX_MHZ = 3200,
  parameter int unsigned OUT_MIN_MHZ = 16,
  parameter int unsigned OUT_MAX_MHZ = 3200,
  parameter int unsigned FB_MIN      = 16,
  parameter int unsigned FB_MAX      = 3200
) (
  input  pll_req_t req_i,
  output logic     legal_o
);
  localparam int unsigned CW = 32;

  logic [CW-1:0] vco_x_ref;  // VCO * refdiv, in MHz
  logic [CW-1:0] ref_w, div_all, fb_w;
  logic          fields_ok, vco_ok, out_ok;

  always_comb begin
    fb_w      = CW'(req_i.fbdiv);
    ref_w     = CW'(req_i.refdiv);
    div_all   = ref_w * CW'(req_i.pd1) * CW'(req_i.pd2);
    vco_x_ref = CW'(REF_MHZ) * fb_w;
    fields_ok = (CW'(req_i.pll) < CW'(NUM_PLL)) && (req_i.refdiv != '0) &&
                (req_i.pd1 != '0) && (req_i.pd2 != '0) &&
                (fb_w >= CW'(FB_MIN)) && (fb_w <= CW'(FB_MAX));
    // cross-multiplied bounds avoid any divider
    vco_ok    = (vco_x_ref >= CW'(VCO_MIN_MHZ) * ref_w) &&
                (vco_x_ref <= CW'(VCO_MAX_MHZ) * ref_w);
    out_ok    = (vco_x_ref >= CW'(OUT_MIN_MHZ) * div_all) &&
                (vco_x_ref <= CW'(OUT_MAX_MHZ) * div_all);
    legal_o   = fields_ok && vco_ok && out_ok;
  end
endmodule

// File: rtl/pll_step_decode.sv
module pll_step_decode
  import pll_seq_pkg::*;
(
  input  seq_state_e        state_i,
  input  pll_req_t          req_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] val_o
);
  logic [DATA_W-1:0] mode_bit;
  logic [ADDR_W-1:0] w0_addr, w1_addr;

  always_comb begin
    mode_bit = DATA_W'(1) << mode_pos(req_i.pll);
    w0_addr  = ctl_addr(req_i.pll, 1'b0);
    w1_addr  = ctl_addr(req_i.pll, 1'b1);
    we_o     = 1'b0;
    addr_o   = MODE_ADDR;
    mask_o   = '0;
    val_o    = '0;
    unique case (state_i)
      ST_SLOW: begin
        we_o = 1'b1; mask_o = mode_bit;
      end
      ST_INT: begin
        we_o = 1'b1; addr_o = w1_addr;
        mask_o = DATA_W'(1) << INT_BIT; val_o = mask_o;
      end
      ST_DIV0: begin
        we_o   = 1'b1; addr_o = w0_addr;
        mask_o = (((DATA_W'(1) << FBDIV_W) - DATA_W'(1)) << FB_LSB) |
                 (((DATA_W'(1) << PDIV_W) - DATA_W'(1)) << PD1_LSB);
        val_o  = (DATA_W'(req_i.fbdiv) << FB_LSB) | (DATA_W'(req_i.pd1) << PD1_LSB);
      end
      ST_DIV1: begin
        we_o   = 1'b1; addr_o = w1_addr;
        mask_o = (((DATA_W'(1) << REFDIV_W) - DATA_W'(1)) << REF_LSB) |
                 (((DATA_W'(1) << PDIV_W) - DATA_W'(1)) << PD2_LSB);
        val_o  = (DATA_W'(req_i.refdiv) << REF_LSB) | (DATA_W'(req_i.pd2) << PD2_LSB);
      end
      ST_POLL: addr_o = w1_addr;
      ST_NORM: begin
        we_o = 1'b1; mask_o = mode_bit; val_o = mode_bit;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  logic [CNT_W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int unsigned REF_MHZ      = 24,
  parameter int unsigned VCO_MIN_MHZ  = 800,
  parameter int unsigned VCO_MAX_MHZ  = 3200,
  parameter int unsigned OUT_MIN_MHZ  = 16,
  parameter int unsigned OUT_MAX_MHZ  = 3200,
  parameter int unsigned FB_MIN       = 16,
  parameter int unsigned FB_MAX       = 3200,
  parameter int unsigned LOCK_TIMEOUT = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [IDX_W-1:0]    req_pll_i,
  input  logic [REFDIV_W-1:0] req_refdiv_i,
  input  logic [FBDIV_W-1:0]  req_fbdiv_i,
  input  logic [PDIV_W-1:0]   req_pd1_i,
  input  logic [PDIV_W-1:0]   req_pd2_i,
  output logic [ADDR_W-1:0]   rd_addr_o,
  input  logic [DATA_W-1:0]   rd_data_i,
  output logic                wr_en_o,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_illegal_o,
  output logic                err_timeout_o
);
  seq_state_e        state_q;
  pll_req_t          req_in, req_q;
  logic              legal, expired, locked;
  logic [ADDR_W-1:0] step_addr;
  logic [DATA_W-1:0] step_mask, step_val;
  logic              done_q, ill_q, to_q;

  assign req_in = '{pll: req_pll_i, refdiv: req_refdiv_i, fbdiv: req_fbdiv_i,
                    pd1: req_pd1_i, pd2: req_pd2_i};

  pll_req_check #(
    .REF_MHZ(REF_MHZ), .VCO_MIN_MHZ(VCO_MIN_MHZ), .VCO_MAX_MHZ(VCO_MAX_MHZ),
    .OUT_MIN_MHZ(OUT_MIN_MHZ), .OUT_MAX_MHZ(OUT_MAX_MHZ),
    .FB_MIN(FB_MIN), .FB_MAX(FB_MAX)
  ) u_check (
    .req_i(req_in), .legal_o(legal)
  );

  pll_step_decode u_decode (
    .state_i(state_q), .req_i(req_q), .we_o(wr_en_o),
    .addr_o(step_addr), .mask_o(step_mask), .val_o(step_val)
  );

  pll_lock_timer #(.LIMIT(LOCK_TIMEOUT)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(state_q == ST_POLL), .expired_o(expired)
  );

  assign rd_addr_o     = step_addr;
  assign wr_addr_o     = step_addr;
  assign wr_data_o     = (rd_data_i & ~step_mask) | (step_val & step_mask);
  assign locked        = rd_data_i[LOCK_BIT];
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign err_illegal_o = ill_q;
  assign err_timeout_o = to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= '0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      to_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          if (legal) begin
            req_q   <= req_in;
            state_q <= ST_SLOW;
          end else begin
            ill_q <= 1'b1;
          end
        end
        ST_SLOW: state_q <= ST_INT;
        ST_INT:  state_q <= ST_DIV0;
        ST_DIV0: state_q <= ST_DIV1;
        ST_DIV1: state_q <= ST_POLL;
        ST_POLL: begin
          if (locked) state_q <= ST_NORM;
          else if (expired) begin
            to_q    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_NORM: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk
  import pll_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              busy_o,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              done_o,
  input logic              err_illegal_o,
  input logic              err_timeout_o
);
  assert_write_only_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o);

  assert_busy_needs_request_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i));

  assert_first_write_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (wr_en_o && wr_addr_o == MODE_ADDR));

  assert_illegal_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_illegal_o |-> (!busy_o && !$past(wr_en_o)));

  assert_done_after_mode_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(wr_en_o) && $past(wr_addr_o) == MODE_ADDR && !busy_o));

  assert_timeout_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_timeout_o |-> ($past(busy_o) && !$past(wr_en_o) && !busy_o));

  assert_single_outcome_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_illegal_o, err_timeout_o}));
endmodule

bind pll_reprog_seq pll_reprog_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .busy_o(busy_o),
  .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .done_o(done_o),
  .err_illegal_o(err_illegal_o), .err_timeout_o(err_timeout_o)
);

// File: tb/pll_reprog_seq_tb.sv
`timescale 1ns/1ps
module pll_reprog_seq_tb;
  localparam int LOCK_DLY = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_pll = '0;
  logic [5:0]  req_ref = '0;
  logic [11:0] req_fb = '0;
  logic [2:0]  req_p1 = '0, req_p2 = '0;
  logic [3:0]  rd_addr, wr_addr;
  logic [15:0] rd_data, wr_data;
  logic        wr_en, busy, done, err_ill, err_to;

  logic [15:0] regs [0:15];
  logic        lock [0:4];
  int          lcnt [0:4];
  bit          no_lock = 0;
  int          checks = 0, fails = 0;
  bit          finished = 0;
  int          mpos [0:4] = '{0, 1, 4, 8, 12};

  typedef struct { int kind; logic [3:0] addr; logic [15:0] data; string tag; } item_t;
  item_t exp_q [$];

  always #2.5 clk = ~clk;

  pll_reprog_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_pll_i(req_pll),
    .req_refdiv_i(req_ref), .req_fbdiv_i(req_fb), .req_pd1_i(req_p1), .req_pd2_i(req_p2),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .busy_o(busy), .done_o(done), .err_illegal_o(err_ill),
    .err_timeout_o(err_to)
  );

  // register file and PLL lock model
  always_comb begin
    rd_data = regs[rd_addr];
    if (rd_addr >= 4'd2 && rd_addr <= 4'd10 && !rd_addr[0])
      rd_data[10] = lock[int'(rd_addr) / 2 - 1];
  end

  always @(posedge clk) begin
    if (wr_en) regs[wr_addr] <= wr_data;
    for (int p = 0; p < 5; p++) begin
      if (wr_en && wr_addr == 4'(1 + 2 * p)) begin
        lock[p] <= 1'b0;
        lcnt[p] <= LOCK_DLY;
      end else if (lcnt[p] != 0) begin
        lcnt[p] <= lcnt[p] - 1;
        if (lcnt[p] == 1 && !no_lock) lock[p] <= 1'b1;
      end
    end
  end

  task automatic push(int k, logic [3:0] a, logic [15:0] d, string t);
    item_t it;
    it.kind = k; it.addr = a; it.data = d; it.tag = t;
    exp_q.push_back(it);
  endtask

  task automatic take(int k, logic [3:0] a, logic [15:0] d);
    item_t it;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R10: unexpected event kind=%0d addr=%0d data=%h, expected none", k, a, d);
    end else begin
      it = exp_q.pop_front();
      if (it.kind != k || it.addr != a || it.data != d) begin
        fails++;
        $display("FAIL %s: kind=%0d addr=%0d data=%h, expected kind=%0d addr=%0d data=%h",
                 it.tag, k, a, d, it.kind, it.addr, it.data);
      end
    end
  endtask

  // monitor
  always @(negedge clk) if (rst_n && !finished) begin
    if (wr_en)   take(0, wr_addr, wr_data);
    if (done)    take(1, 4'd0, 16'd0);
    if (err_ill) take(2, 4'd0, 16'd0);
    if (err_to)  take(3, 4'd0, 16'd0);
  end

  task automatic check(bit ok, string msg, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", msg, act, expv);
    end
  endtask

  function automatic bit is_legal(int p, int r, int f, int q1, int q2);
    int v = 24 * f;
    return p < 5 && r != 0 && q1 != 0 && q2 != 0 && f >= 16 && f <= 3200 &&
           v >= 800 * r && v <= 3200 * r && v >= 16 * r * q1 * q2 && v <= 3200 * r * q1 * q2;
  endfunction

  task automatic expect_seq(int p, int r, int f, int q1, int q2, string ltag);
    logic [15:0] bitm, m1, w1a, w0v, w1b;
    logic [3:0]  a0, a1;
    if (!is_legal(p, r, f, q1, q2)) begin
      push(2, 0, 0, ltag);
      return;
    end
    a0   = 4'(1 + 2 * p);
    a1   = 4'(2 + 2 * p);
    bitm = 16'd1 << mpos[p];
    m1   = regs[0] & ~bitm;
    push(0, 4'd0, m1, "R4/R7");
    w1a  = regs[a1];
    w1a[10] = lock[p];
    w1a  = w1a | 16'h1000;
    push(0, a1, w1a, "R5/R7");
    w0v  = (regs[a0] & ~16'h7FFF) | (16'(q1) << 12) | 16'(f);
    push(0, a0, w0v, "R6/R7");
    w1b  = w1a;
    w1b[10] = 1'b0;
    w1b  = (w1b & ~16'h01FF) | (16'(q2) << 6) | 16'(r);
    push(0, a1, w1b, "R6/R7");
    if (no_lock) push(3, 0, 0, "R9");
    else begin
      push(0, 4'd0, m1 | bitm, "R8");
      push(1, 0, 0, "R8");
    end
  endtask

  task automatic drive(int p, int r, int f, int q1, int q2);
    @(negedge clk);
    req_valid = 1'b1;
    req_pll = 3'(p); req_ref = 6'(r); req_fb = 12'(f); req_p1 = 3'(q1); req_p2 = 3'(q2);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (exp_q.size() == 0 && !busy) break;
      @(negedge clk);
    end
    check(exp_q.size() == 0, "R8 pending events", exp_q.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic run(int p, int r, int f, int q1, int q2, string ltag);
    bit lg = is_legal(p, r, f, q1, q2);
    expect_seq(p, r, f, q1, q2, ltag);
    drive(p, r, f, q1, q2);
    if (!lg) check(busy == 1'b0, "R3 busy after illegal", busy, 0);
    wait_idle();
  endtask

  initial begin
    logic [15:0] s5, s6, sm;
    for (int i = 0; i < 16; i++) regs[i] = 16'hFFFF ^ 16'(i * 16'h0123);
    regs[0] = 16'hFFFF;
    for (int p = 0; p < 5; p++) begin lock[p] = 1'b0; lcnt[p] = 0; end
    repeat (3) @(negedge clk);
    check(!busy && !wr_en && !done && !err_ill && !err_to, "R11 reset outputs",
          {busy, wr_en, done, err_ill, err_to}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(4, 1, 50, 4, 1, "R1");        // VCO 1200, out 300
    run(0, 2, 100, 2, 1, "R1");       // VCO 1200, out 600
    run(2, 24, 3200, 1, 1, "R1");     // R1/R2 upper bounds exactly: VCO 3200, out 3200
    run(1, 3, 100, 7, 7, "R1");       // VCO exactly 800
    run(0, 1, 34, 2, 1, "R1");        // lock already high when word 1 first read
    run(3, 1, 20, 1, 1, "R1");        // VCO 480: illegal
    run(3, 1, 134, 2, 1, "R1");       // VCO 3216: illegal
    run(3, 40, 3300, 2, 1, "R1");     // fbdiv above 3200: illegal
    run(3, 24, 3200, 1, 2, "R2");     // legal, out 1600
    run(3, 0, 50, 2, 1, "R2");        // refdiv zero
    run(3, 1, 50, 0, 1, "R2");        // postdiv1 zero
    run(5, 1, 50, 2, 1, "R2");        // index out of range

    // R9: lock never arrives
    no_lock = 1;
    run(1, 1, 50, 2, 2, "R9");
    check(regs[0][1] == 1'b0, "R9 mode bit stays slow", regs[0][1], 0);
    no_lock = 0;

    // R10: request during busy is ignored
    s5 = regs[5]; s6 = regs[6]; sm = regs[0];
    expect_seq(0, 1, 40, 3, 1, "R10");
    drive(0, 1, 40, 3, 1);
    @(negedge clk);
    check(busy == 1'b1, "R10 busy during sequence", busy, 1);
    drive(2, 1, 60, 2, 1);
    wait_idle();
    check(regs[5] == s5, "R10 ignored request word0", regs[5], s5);
    check(regs[6] == s6, "R10 ignored request word1", regs[6], s6);
    check(regs[0][4] == sm[4], "R10 ignored request mode", regs[0][4], sm[4]);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R8: watchdog expired, actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule